// File: doc/BRIEF.md
# Rate-1/5 Tail-Biting Convolutional Encoder

This block applies a 64-state convolutional code of native rate 1/5 to a short control payload of 7 to 24 bits. The code is tail-biting. The shift register starts in the state it will end in, so no tail bits are added. Every information bit yields five coded bits, one from each of five generators. The coded bits leave as five back-to-back subblocks, named A to E, each L bits long. Subblocks A and B together form the codeword of the legacy rate-1/2 code with the same first two generators.

A request carries the payload in parallel with its length. It is offered on a valid/ready input and accepted in one cycle. All five parity streams are formed in parallel on acceptance and stored. The serial output is valid/ready: a bit moves on a cycle where both `out_valid` and `out_ready` are high. While `out_ready` is low the presented bit, subblock tag and last flag are held. A new request is refused (`in_ready` low) until the final bit of subblock E has moved. A length outside the supported range is reported on `len_err` and produces no output.

Top module: `tbcc5_encoder`

## Requirements
- R1: After reset `out_valid`, `out_last` and `len_err` are low and `in_ready` is high.
- R2: A request is accepted only on a cycle with `in_valid` and `in_ready` high. `in_ready` stays low from acceptance until the last output bit has moved, and requests offered in that time are ignored.
- R3: A request whose `in_len` is outside 7..24 raises `len_err` for exactly the one cycle after acceptance. It produces no output, and `in_ready` stays high.
- R4: For a valid length L the output is exactly 5L bits. First come all L bits of subblock A, in input-bit order i = 0..L-1, then B, C, D and E. `out_sub` gives the subblock as 0=A, 1=B, 2=C, 3=D, 4=E.
- R5: Coded bit i of a subblock is the XOR of the window {u[i], u[i-1], ..., u[i-6]} masked by that subblock's generator. The generators are octal 171 (A), 133 (B), 165 (C), 117 (D) and 127 (E). Generator bit 6 taps u[i] and bit 0 taps u[i-6]. Indices below zero wrap modulo L (tail-biting).
- R6: Information bit u[i] is `in_data[i]`. Bits of `in_data` at positions L and above have no effect.
- R7: `out_last` is high only on the final bit (i = L-1) of subblock E.
- R8: While `out_valid` is high and `out_ready` is low, `out_bit`, `out_sub` and `out_last` hold and `out_valid` stays high.
- R9: `out_valid` rises the cycle after a valid request is accepted, presenting A bit 0. `in_ready` returns high the cycle after the last bit has moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Encoder idle, request can be taken |
| in_data | input | 24 | Payload, bit i is information bit i |
| in_len | input | 5 | Payload length L |
| out_valid | output | 1 | Coded bit presented |
| out_ready | input | 1 | Downstream takes the coded bit |
| out_bit | output | 1 | Coded bit |
| out_sub | output | 3 | Subblock of the coded bit, 0..4 for A..E |
| out_last | output | 1 | Final coded bit of the frame |
| len_err | output | 1 | One-cycle pulse for an unsupported length |

## Verification
Results are due at fixed offsets from the accepting edge. `len_err` or the first coded bit appears after exactly one register stage. After that, one coded bit moves per edge on which `out_ready` is high. `in_ready` returns one edge after the final handshake. The bench drives inputs at the falling edge and samples one nanosecond later in the same low phase. It predicts the bit that moves at the coming rising edge whenever it has set `out_ready` high, and expects a stalled bit to repeat on the next sample. Expected bits come from a shift-register model preloaded with the last six payload bits, run under three back-pressure patterns.

// File: rtl/tbcc5_pkg.sv
package tbcc5_pkg;

  localparam int NGEN = 5;
  localparam int KLEN = 7;
  localparam int SUBW = 3;

  typedef enum logic [SUBW-1:0] {
    SB_A = 3'd0,
    SB_B = 3'd1,
    SB_C = 3'd2,
    SB_D = 3'd3,
    SB_E = 3'd4
  } sub_e;

  localparam logic [KLEN-1:0] GEN_OCT [NGEN] = '{7'o171, 7'o133, 7'o165, 7'o117, 7'o127};

  // bit k of the mask applies to the input delayed by k cycles
  function automatic logic [KLEN-1:0] delay_mask(int s);
    logic [KLEN-1:0] m;
    for (int k = 0; k < KLEN; k++) m[k] = GEN_OCT[s][KLEN-1-k];
    return m;
  endfunction

endpackage

// File: rtl/tbcc_tap_window.sv
module tbcc_tap_window
  import tbcc5_pkg::*;
#(
  parameter int MAX_LEN = 24,
  parameter int LENW    = $clog2(MAX_LEN + 1)
) (
  input  logic [MAX_LEN-1:0]           data_i,
  input  logic [LENW-1:0]              len_i,
  output logic [MAX_LEN-1:0][KLEN-1:0] taps_o
);

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_pos
    for (genvar k = 0; k < KLEN; k++) begin : g_dly
      if (i >= k) begin : g_direct
        assign taps_o[i][k] = data_i[i-k];
      end else begin : g_wrap
        // circular wrap: position i-k maps to L-(k-i)
        logic [LENW-1:0] pos;
        assign pos = len_i - LENW'(k - i);
        assign taps_o[i][k] = (pos < LENW'(MAX_LEN)) ? data_i[pos] : 1'b0;
      end
    end
  end

endmodule

// File: rtl/tbcc_gen_xor.sv
module tbcc_gen_xor
  import tbcc5_pkg::*;
#(
  parameter int              MAX_LEN = 24,
  parameter logic [KLEN-1:0] MASK    = 7'b1001111
) (
  input  logic [MAX_LEN-1:0][KLEN-1:0] taps_i,
  output logic [MAX_LEN-1:0]           coded_o
);

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_bit
    assign coded_o[i] = ^(taps_i[i] & MASK);
  end

endmodule

// File: rtl/tbcc_frame_sequencer.sv
module tbcc_frame_sequencer
  import tbcc5_pkg::*;
#(
  parameter int MAX_LEN = 24,
  parameter int LENW    = $clog2(MAX_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [LENW-1:0] len_i,
  input  logic            ready_i,
  output logic            busy_o,
  output sub_e            sub_o,
  output logic [LENW-1:0] idx_o,
  output logic            last_o
);

  logic            busy_q;
  sub_e            sub_q;
  logic [LENW-1:0] idx_q;
  logic [LENW-1:0] len_q;
  logic            end_of_sub;

  assign end_of_sub = (idx_q == len_q - LENW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sub_q  <= SB_A;
      idx_q  <= '0;
      len_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      sub_q  <= SB_A;
      idx_q  <= '0;
      len_q  <= len_i;
    end else if (busy_q && ready_i) begin
      if (end_of_sub) begin
        idx_q <= '0;
        if (sub_q == SB_E) busy_q <= 1'b0;
        else               sub_q  <= sub_e'(sub_q + 3'd1);
      end else begin
        idx_q <= idx_q + LENW'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign sub_o  = sub_q;
  assign idx_o  = idx_q;
  assign last_o = busy_q && end_of_sub && (sub_q == SB_E);

  // R8: a stalled output is held
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ready_i && !load_i) |=> (busy_q && $stable(sub_q) && $stable(idx_q)));

  // R4: position stays inside the payload while busy
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q < len_q));

  // R4: a moved bit that is not the last leaves the frame running
  a_r4_continue: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ready_i && !last_o) |=> busy_q);

endmodule

// File: rtl/tbcc5_encoder.sv
module tbcc5_encoder
  import tbcc5_pkg::*;
#(
  parameter int MAX_LEN = 24,
  parameter int MIN_LEN = 7,
  parameter int LENW    = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [MAX_LEN-1:0] in_data,
  input  logic [LENW-1:0]    in_len,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_bit,
  output logic [SUBW-1:0]    out_sub,
  output logic               out_last,
  output logic               len_err
);

  logic [MAX_LEN-1:0][KLEN-1:0] taps_w;
  logic [NGEN-1:0][MAX_LEN-1:0] coded_w;
  logic [NGEN-1:0][MAX_LEN-1:0] coded_q;
  logic                         accept, len_ok, load, busy, err_q;
  sub_e                         sub_w;
  logic [LENW-1:0]              idx_w;

  assign accept = in_valid && in_ready;
  assign len_ok = (in_len >= LENW'(MIN_LEN)) && (in_len <= LENW'(MAX_LEN));
  assign load   = accept && len_ok;

  tbcc_tap_window #(.MAX_LEN(MAX_LEN), .LENW(LENW)) u_window (
    .data_i (in_data),
    .len_i  (in_len),
    .taps_o (taps_w)
  );

  for (genvar s = 0; s < NGEN; s++) begin : g_gen
    tbcc_gen_xor #(.MAX_LEN(MAX_LEN), .MASK(delay_mask(s))) u_xor (
      .taps_i  (taps_w),
      .coded_o (coded_w[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coded_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (load) coded_q <= coded_w;
      err_q <= accept && !len_ok;
    end
  end

  tbcc_frame_sequencer #(.MAX_LEN(MAX_LEN), .LENW(LENW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .len_i   (in_len),
    .ready_i (out_ready),
    .busy_o  (busy),
    .sub_o   (sub_w),
    .idx_o   (idx_w),
    .last_o  (out_last)
  );

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_sub   = sub_w;
  assign out_bit   = (int'(sub_w) < NGEN && int'(idx_w) < MAX_LEN) ? coded_q[sub_w][idx_w] : 1'b0;
  assign len_err   = err_q;

  // R3: an error pulse never coincides with output activity
  a_r3_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (!out_valid && in_ready));

  // R3: the pulse lasts one cycle
  a_r3_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> (!len_err || $past(in_valid && in_ready)));

  // R9: a valid request starts subblock A on the next cycle
  a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_len >= LENW'(MIN_LEN) && in_len <= LENW'(MAX_LEN))
      |=> (out_valid && out_sub == SB_E - 3'd4));

  // R7: last flag only inside subblock E
  a_r7_last_in_e: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_sub == SB_E));

  // R7/R9: the frame ends after the last handshake
  a_r7_end: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

  // R8: stalled output data is held
  a_r8_stable_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_sub) && $stable(out_last)));

endmodule

// File: tb/tbcc5_encoder_tb_top.sv
`timescale 1ns/1ps
module tbcc5_encoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_data = '0;
  logic [4:0]  in_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_bit;
  logic [2:0]  out_sub;
  logic        out_last;
  logic        len_err;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tbcc5_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_len(in_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .out_sub(out_sub), .out_last(out_last), .len_err(len_err)
  );

  localparam int NV = 8;
  localparam logic [23:0] V_PAY [NV] = '{24'h000000, 24'hFFFFFF, 24'h00007F, 24'hA5C3F1,
                                         24'h5A5A5A, 24'hFF0055, 24'h123456, 24'hFC0001};
  localparam logic [4:0]  V_LEN [NV] = '{5'd7, 5'd24, 5'd7, 5'd24, 5'd12, 5'd9, 5'd16, 5'd10};
  localparam int          V_BP  [NV] = '{0, 0, 1, 2, 1, 0, 2, 1};

  function automatic logic model_bit(logic [23:0] u, int len, int s, int i);
    logic [6:0] g [5] = '{7'o171, 7'o133, 7'o165, 7'o117, 7'o127};
    logic [5:0] st;
    logic [6:0] win;
    logic o = 1'b0;
    for (int m = 0; m < 6; m++) st[5-m] = u[len-1-m];
    for (int j = 0; j <= i; j++) begin
      win = {u[j], st};
      o   = ^(win & g[s]);
      st  = win[6:1];
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ready_pat(int mode, int c);
    case (mode)
      0:       return 1'b1;
      1:       return (c % 2) == 1;
      default: return (c % 3) == 2;
    endcase
  endfunction

  task automatic run_frame(input logic [23:0] pay, input int len, input int mode, input bit hold_req);
    int s = 0, i = 0, c = 0;
    bit stalled = 0;
    logic held_bit;
    logic [2:0] held_sub;
    @(negedge clk);
    in_data = pay; in_len = 5'(len); in_valid = 1'b1;
    @(negedge clk);
    if (hold_req) begin in_data = ~pay; in_len = 5'd24; end
    else in_valid = 1'b0;
    #1;
    check(out_valid == 1'b1 && out_sub == 3'd0, "R9 start", int'(out_valid), 1);
    check(in_ready == 1'b0, "R2 busy", int'(in_ready), 0);
    while (s < 5) begin
      out_ready = ready_pat(mode, c);
      #1;
      if (stalled)
        check(out_bit == held_bit && out_sub == held_sub && out_valid, "R8 hold",
              int'(out_bit), int'(held_bit));
      if (out_valid && out_ready) begin
        check(out_bit == model_bit(pay, len, s, i), "R5 coded bit", int'(out_bit),
              int'(model_bit(pay, len, s, i)));
        check(out_sub == 3'(s), "R4 subblock", int'(out_sub), s);
        check(out_last == (s == 4 && i == len - 1), "R7 last", int'(out_last),
              int'(s == 4 && i == len - 1));
        stalled = 0;
        if (i == len - 1) begin i = 0; s++; end else i++;
      end else begin
        stalled = out_valid; held_bit = out_bit; held_sub = out_sub;
      end
      c++;
      @(negedge clk);
      if (s == 5) in_valid = 1'b0;
    end
    out_ready = 1'b0;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R4 R9 frame end", int'(out_valid), 0);
  endtask

  task automatic bad_len(input int len);
    @(negedge clk);
    in_data = 24'hFFFFFF; in_len = 5'(len); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(len_err == 1'b1, "R3 err pulse", int'(len_err), 1);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R3 no output", int'(out_valid), 0);
    @(negedge clk); #1;
    check(len_err == 1'b0 && out_valid == 1'b0, "R3 err one cycle", int'(len_err), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 0 && out_last == 0 && len_err == 0 && in_ready == 1, "R1 reset",
          int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 after release", int'(in_ready), 1);

    for (int v = 0; v < NV; v++) run_frame(V_PAY[v], int'(V_LEN[v]), V_BP[v], 1'b0);

    // R6: garbage above L must not change the coded bits
    run_frame(24'hFFFF80 | 24'h000035, 7, 0, 1'b0);
    // R2: request held during a frame is ignored
    run_frame(24'h00C0DE, 11, 1, 1'b1);
    @(negedge clk); in_valid = 1'b0;
    repeat (2) @(negedge clk);

    bad_len(6);
    bad_len(25);
    bad_len(0);
    bad_len(31);

    // boundary lengths after errors still encode
    run_frame(24'h000041, 7, 2, 1'b0);
    run_frame(24'h800001, 24, 1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule